// File: doc/BRIEF.md
# Reference Oscillator Frequency Classifier

This block decides which standard crystal frequency feeds the system input clock. It runs on that fast clock and measures it against a slow reference tick of about 32.768 kHz. When a start pulse is accepted, the block lets a number of reference ticks pass to settle, with the first tick usually only partial. It then takes a snapshot of a free-running cycle counter and counts fast cycles across a fixed window of reference ticks. The count is doubled when a divide-by-2 prescaler sits in front of the clock. The block then sorts the count into one of six frequency classes.

From the class it derives a 3-bit input-select code, a table index for the parameter tables used by later setup logic, and a prescaler field. A one-cycle done pulse marks each new result. The results hold until the next measurement completes.

The control is a four-state machine:

- **IDLE**: waits for start. IDLE goes to SETTLE when start is high.
- **SETTLE**: counts discarded ticks. SETTLE goes to SPAN on the last settle tick, which is also when the snapshot is taken.
- **SPAN**: counts window ticks. SPAN goes to REPORT on the last window tick, which is when the span is computed.
- **REPORT**: registers the classification and raises done. REPORT returns to IDLE unconditionally.

Top module: `osc_freq_classifier`

## Requirements
- R1: After a start is accepted, the first WAIT_TICKS synchronized reference ticks are discarded (default 20). The cycle counter snapshot is taken on the clock edge that absorbs the last of them.
- R2: The measured span is the number of clock edges from the snapshot edge to the edge that absorbs the WIN_TICKS-th following tick (default 20). It is computed as a modular unsigned difference of cycle counter values.
- R3: The prescaler flag `div2_on` is captured when start is accepted. When it is 1, the span is doubled before classification.
- R4: Classification compares the scaled count strictly (greater-than), highest class first. The classes and `freq_code` values are:
  - count > 19000 gives 38.4 MHz, code 5.
  - count > 15200 gives 26 MHz, code 4.
  - count > 13000 gives 24 MHz, code 3.
  - count > 9000 gives 19.2 MHz, code 2.
  - count > 7600 gives 13 MHz, code 1.
  - Any other count gives 12 MHz, code 0.
- R5: `sel_code` is 4 for 38.4 MHz, 3 for 26 MHz, 2 for 19.2 MHz and 1 for 13 MHz. It is 0 for 12 MHz and also for 24 MHz.
- R6: When `sel_code` is above 2, `presc_field` is 2 (divide-by-2) and `tbl_idx` is `sel_code`/2. Otherwise `presc_field` is 1 (divide-by-1) and `tbl_idx` equals `sel_code`.
- R7: `ref_in` passes through a two-flop synchronizer and a rising-edge detector. A rising level applied between clock edges is absorbed as a tick on the third following clock edge.
- R8: `done` is high for exactly one cycle, in the cycle after the edge that absorbs the last window tick. All result outputs change together with `done` and hold their values at all other times.
- R9: A start pulse that arrives while a measurement is in progress (SETTLE, SPAN or REPORT) has no effect. This includes the `div2_on` value present with it.
- R10: After reset, the block is in IDLE, `done` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Slow reference tick, asynchronous to clk |
| start | input | 1 | Start a measurement (accepted in IDLE only) |
| div2_on | input | 1 | Divide-by-2 prescaler is active |
| freq_code | output | 3 | Frequency class, 0..5 as in R4 |
| sel_code | output | 3 | Input-select code as in R5 |
| tbl_idx | output | 2 | Parameter table index as in R6 |
| presc_field | output | 2 | Prescaler setting: 1 = divide-by-1, 2 = divide-by-2 |
| done | output | 1 | One-cycle result strobe |

## Verification
A reference rise driven just after clock edge k is absorbed at edge k+3. The state leaves SPAN on the edge that absorbs the final window tick, and `done` and every result output then change on the next edge. The bench keeps a per-edge behavioural model that records the predicted absorption edges in a queue and reproduces that schedule. It compares `done` and all results against the model on every falling edge, half a period away from the edges where they change. For each case it also checks the class, select code, index and prescaler field it expects from the period it drives.

// File: rtl/oscfc_pkg.sv
package oscfc_pkg;

    // Frequency class encoding (matches R4)
    typedef enum logic [2:0] {
        FQ_12M  = 3'd0,
        FQ_13M  = 3'd1,
        FQ_19M2 = 3'd2,
        FQ_24M  = 3'd3,
        FQ_26M  = 3'd4,
        FQ_38M4 = 3'd5
    } freq_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SPAN,
        ST_REPORT
    } state_e;

    // Lower bounds (exclusive) of each class, in scaled cycle counts
    localparam int unsigned LIM_38M4 = 19000;
    localparam int unsigned LIM_26M  = 15200;
    localparam int unsigned LIM_24M  = 13000;
    localparam int unsigned LIM_19M2 = 9000;
    localparam int unsigned LIM_13M  = 7600;

    localparam logic [1:0] PRESC_DIV1 = 2'd1;
    localparam logic [1:0] PRESC_DIV2 = 2'd2;

    typedef struct packed {
        freq_e      freq;
        logic [2:0] sel;
        logic [1:0] idx;
        logic [1:0] presc;
    } verdict_t;

endpackage

// File: rtl/oscfc_ref_sync.sv
module oscfc_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic tick
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], ref_in};
        end
    end

    // rising edge of the synchronized level
    assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];

    a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("a_r7_tick_single");

endmodule

// File: rtl/oscfc_grade.sv
module oscfc_grade
    import oscfc_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic [CW:0] count,
    output verdict_t    verdict
);
    localparam logic [CW:0] L38 = (CW+1)'(LIM_38M4);
    localparam logic [CW:0] L26 = (CW+1)'(LIM_26M);
    localparam logic [CW:0] L24 = (CW+1)'(LIM_24M);
    localparam logic [CW:0] L19 = (CW+1)'(LIM_19M2);
    localparam logic [CW:0] L13 = (CW+1)'(LIM_13M);

    freq_e      fq;
    logic [2:0] sel;

    // strict comparisons, highest class first
    always_comb begin
        if (count > L38)      fq = FQ_38M4;
        else if (count > L26) fq = FQ_26M;
        else if (count > L24) fq = FQ_24M;
        else if (count > L19) fq = FQ_19M2;
        else if (count > L13) fq = FQ_13M;
        else                  fq = FQ_12M;
    end

    always_comb begin
        unique case (fq)
            FQ_38M4: sel = 3'd4;
            FQ_26M:  sel = 3'd3;
            FQ_19M2: sel = 3'd2;
            FQ_13M:  sel = 3'd1;
            default: sel = 3'd0;
        endcase
    end

    always_comb begin
        verdict.freq = fq;
        verdict.sel  = sel;
        if (sel > 3'd2) begin
            verdict.idx   = 2'(sel >> 1);
            verdict.presc = PRESC_DIV2;
        end else begin
            verdict.idx   = sel[1:0];
            verdict.presc = PRESC_DIV1;
        end
    end

endmodule

// File: rtl/osc_freq_classifier.sv
module osc_freq_classifier
    import oscfc_pkg::*;
#(
    parameter int CW          = 32,
    parameter int WAIT_TICKS  = 20,
    parameter int WIN_TICKS   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       start,
    input  logic       div2_on,
    output logic [2:0] freq_code,
    output logic [2:0] sel_code,
    output logic [1:0] tbl_idx,
    output logic [1:0] presc_field,
    output logic       done
);
    localparam int MAXT = (WAIT_TICKS > WIN_TICKS) ? WAIT_TICKS : WIN_TICKS;
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(WAIT_TICKS - 1);
    localparam logic [TW-1:0] SPAN_LAST   = TW'(WIN_TICKS - 1);

    state_e        state_q, state_d;
    logic          tick;
    logic [TW-1:0] tcnt_q;
    logic [CW-1:0] cyc_q, snap_q, span_q;
    logic          div2_q;
    logic [CW:0]   scaled;
    verdict_t      verdict;
    logic          accept, last_settle, last_span;

    oscfc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .tick   (tick)
    );

    assign accept      = (state_q == ST_IDLE) && start;
    assign last_settle = tick && (tcnt_q == SETTLE_LAST);
    assign last_span   = tick && (tcnt_q == SPAN_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)       state_d = ST_SETTLE;
            ST_SETTLE: if (last_settle) state_d = ST_SPAN;
            ST_SPAN:   if (last_span)   state_d = ST_REPORT;
            ST_REPORT:                  state_d = ST_IDLE;
        endcase
    end

    // counters, snapshot and span
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            tcnt_q <= '0;
            snap_q <= '0;
            span_q <= '0;
            div2_q <= 1'b0;
        end else begin
            cyc_q <= accept ? '0 : cyc_q + 1'b1;
            if (accept) begin
                tcnt_q <= '0;
                div2_q <= div2_on;
            end else if (((state_q == ST_SETTLE) || (state_q == ST_SPAN)) && tick) begin
                if (((state_q == ST_SETTLE) && last_settle) || ((state_q == ST_SPAN) && last_span))
                    tcnt_q <= '0;
                else
                    tcnt_q <= tcnt_q + 1'b1;
            end
            if ((state_q == ST_SETTLE) && last_settle) snap_q <= cyc_q;
            if ((state_q == ST_SPAN) && last_span)     span_q <= cyc_q - snap_q;
        end
    end

    assign scaled = div2_q ? {span_q, 1'b0} : {1'b0, span_q};

    oscfc_grade #(.CW(CW)) u_grade (
        .count   (scaled),
        .verdict (verdict)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done        <= 1'b0;
            freq_code   <= '0;
            sel_code    <= '0;
            tbl_idx     <= '0;
            presc_field <= '0;
        end else begin
            done <= (state_q == ST_REPORT);
            if (state_q == ST_REPORT) begin
                freq_code   <= verdict.freq;
                sel_code    <= verdict.sel;
                tbl_idx     <= verdict.idx;
                presc_field <= verdict.presc;
            end
        end
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("a_r8_done_pulse");

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({freq_code, sel_code, tbl_idx, presc_field}))
        else $error("a_r8_hold");

    a_r6_presc_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((sel_code > 3'd2) == (presc_field == PRESC_DIV2)))
        else $error("a_r6_presc_pairs");

    a_r5_shared_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (freq_code == FQ_24M)) |-> (sel_code == 3'd0))
        else $error("a_r5_shared_zero");

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_SETTLE) || (state_q == ST_SPAN)) && start) |=> (cyc_q != '0))
        else $error("a_r9_no_restart");

endmodule

// File: tb/osc_freq_classifier_test.sv
module osc_freq_classifier_test;
    localparam int WAITT = 2;
    localparam int WINT  = 20;

    logic clk = 0, rst_n = 0, ref_in = 0, start = 0, div2_on = 0;
    logic [2:0] freq_code, sel_code;
    logic [1:0] tbl_idx, presc_field;
    logic done;

    int n_run = 0, n_fail = 0;
    int edge_n = 0;
    int tick_q[$];
    int ref_per = 0;
    bit cmp_en = 0;
    bit finished = 0;

    // model state
    int m_st = 0, m_cnt = 0, m_snap = 0, m_span = 0;
    bit m_div2 = 0;
    logic [2:0] e_freq = 0, e_sel = 0;
    logic [1:0] e_idx = 0, e_pre = 0;
    logic e_done = 0;

    always #10 clk = ~clk;

    osc_freq_classifier #(.WAIT_TICKS(WAITT), .WIN_TICKS(WINT)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .start(start), .div2_on(div2_on),
        .freq_code(freq_code), .sel_code(sel_code), .tbl_idx(tbl_idx),
        .presc_field(presc_field), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // R4 R5 R6 expectations from a scaled count
    task automatic grade(input int c, output logic [2:0] f, output logic [2:0] s,
                         output logic [1:0] i, output logic [1:0] p);
        if (c > 19000)      begin f = 5; s = 4; end
        else if (c > 15200) begin f = 4; s = 3; end
        else if (c > 13000) begin f = 3; s = 0; end
        else if (c > 9000)  begin f = 2; s = 2; end
        else if (c > 7600)  begin f = 1; s = 1; end
        else                begin f = 0; s = 0; end
        if (s > 2) begin i = 2'(s / 2); p = 2; end
        else       begin i = s[1:0];    p = 1; end
    endtask

    // per-edge behavioural model
    always @(posedge clk) begin
        bit tk;
        edge_n++;
        tk = 0;
        if (tick_q.size() > 0 && tick_q[0] == edge_n) begin
            tk = 1;
            void'(tick_q.pop_front());
        end
        if (!rst_n) begin
            m_st = 0; e_done = 0; e_freq = 0; e_sel = 0; e_idx = 0; e_pre = 0;
        end else begin
            e_done = (m_st == 3);
            case (m_st)
                0: if (start) begin m_st = 1; m_cnt = 0; m_div2 = div2_on; end
                1: if (tk) begin
                       m_cnt++;
                       if (m_cnt == WAITT) begin m_st = 2; m_cnt = 0; m_snap = edge_n; end
                   end
                2: if (tk) begin
                       m_cnt++;
                       if (m_cnt == WINT) begin m_st = 3; m_span = edge_n - m_snap; end
                   end
                default: begin
                    grade(m_div2 ? 2 * m_span : m_span, e_freq, e_sel, e_idx, e_pre);
                    m_st = 0;
                end
            endcase
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(done == e_done, "R1/R2/R7/R8", "done timing", done, e_done);
            chk(freq_code == e_freq, "R4", "freq_code (model)", freq_code, e_freq);
            chk(sel_code == e_sel, "R5", "sel_code (model)", sel_code, e_sel);
            chk(tbl_idx == e_idx, "R6", "tbl_idx (model)", tbl_idx, e_idx);
            chk(presc_field == e_pre, "R6", "presc_field (model)", presc_field, e_pre);
        end
    end

    // reference tick generator, period in clk cycles
    initial begin
        wait (rst_n);
        forever begin
            int p;
            p = (ref_per > 0) ? ref_per : 8;
            repeat (p / 2) @(negedge clk);
            ref_in = 1;
            tick_q.push_back(edge_n + 3);
            repeat (p - p / 2) @(negedge clk);
            ref_in = 0;
        end
    end

    task automatic wait_done(input int per, input string tag);
        int g = 0;
        while (!done && g < 40 * per) begin @(negedge clk); g++; end
        chk(done == 1'b1, tag, "done seen", done, 1);
    endtask

    task automatic run_case(input int per, input bit d2, input logic [2:0] xf, input logic [2:0] xs,
                            input logic [1:0] xi, input logic [1:0] xp, input string tag);
        @(negedge clk);
        ref_per = per;
        repeat (2) @(posedge ref_in);
        @(negedge clk);
        div2_on = d2; start = 1;
        @(negedge clk);
        start = 0; div2_on = 0;
        wait_done(per, tag);
        chk(freq_code == xf, {tag, " R4"}, "freq_code", freq_code, xf);
        chk(sel_code == xs, {tag, " R5"}, "sel_code", sel_code, xs);
        chk(tbl_idx == xi, {tag, " R6"}, "tbl_idx", tbl_idx, xi);
        chk(presc_field == xp, {tag, " R6"}, "presc_field", presc_field, xp);
        @(negedge clk);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(done == 0, "R10", "done in reset", done, 0);
        chk({freq_code, sel_code, tbl_idx, presc_field} == 0, "R10", "results in reset",
            {freq_code, sel_code, tbl_idx, presc_field}, 0);
        rst_n = 1;
        cmp_en = 1;
        @(negedge clk);
        chk(done == 0, "R10", "done after reset", done, 0);

        // span = 20 * period
        run_case(366,  0, 0, 0, 0, 1, "R2 12MHz");
        run_case(397,  0, 1, 1, 1, 1, "R2 13MHz");
        run_case(586,  0, 2, 2, 2, 1, "R2 19.2MHz");
        run_case(732,  0, 3, 0, 0, 1, "R5 24MHz");
        run_case(793,  0, 4, 3, 1, 2, "R6 26MHz");
        run_case(1171, 0, 5, 4, 2, 2, "R6 38.4MHz");
        run_case(380,  0, 0, 0, 0, 1, "R4 boundary 7600");
        run_case(183,  1, 0, 0, 0, 1, "R3 12MHz div2");
        run_case(396,  1, 4, 3, 1, 2, "R3 26MHz div2");
        run_case(585,  1, 5, 4, 2, 2, "R3 38.4MHz div2");

        // R9: second start with prescaler flag mid-measurement is ignored
        @(negedge clk);
        ref_per = 366;
        repeat (2) @(posedge ref_in);
        @(negedge clk);
        start = 1; div2_on = 0;
        @(negedge clk);
        start = 0;
        repeat (5 * 366) @(negedge clk);
        start = 1; div2_on = 1;
        @(negedge clk);
        start = 0; div2_on = 0;
        wait_done(366, "R9");
        chk(freq_code == 0, "R9", "freq_code after ignored start", freq_code, 0);
        chk(presc_field == 1, "R9", "presc_field after ignored start", presc_field, 1);
        repeat (3) @(negedge clk);
        chk(done == 0, "R8", "done low after pulse", done, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule